// File: doc/BRIEF.md
# Widening Register Group Legality Checker

This combinational block sits beside the issue logic of a vector unit. For an instruction whose results are twice as wide as its operands, it works out how many architectural registers the destination group needs. It then decides whether the destination and source register groups may coexist.

The inputs are the current group multiplier code, the first register of the destination, the first register of one source and the size of that source group. The destination multiplier is twice the current one, kept as a fraction in lowest terms. A fraction below one still takes a whole register. A doubled multiplier above 8, or the reserved code, makes the instruction illegal.

Disjoint groups are always accepted. When the groups share registers, the only overlap accepted is a source group that is smaller than the destination and sits exactly in the top registers of the destination group. All outputs follow the inputs in the same cycle.

Top module: `widen_group_chk`

## Requirements
- R1: For multiplier codes 3'b000 (1), 3'b001 (2) and 3'b010 (4), `dst_regs` is 2, 4 and 8 respectively.
- R2: For the fractional codes 3'b101 (1/8), 3'b110 (1/4) and 3'b111 (1/2), the doubled multiplier is at most 1 and `dst_regs` is 1.
- R3: Code 3'b011 (8) doubles to 16. The block raises `illegal` and reports `dst_regs` as 0.
- R4: The reserved code 3'b100 raises `illegal` and reports `dst_regs` as 0, whatever the register operands are.
- R5: If the source begins at or above the destination's end register, or the destination begins at or above the source's end register, the groups are disjoint and `legal` is 1.
- R6: An overlap is legal when `dst_regs` is greater than `src_regs` and `src_reg` equals `dst_reg + dst_regs - src_regs`.
- R7: Every other overlap raises `illegal`. This includes groups of equal size, groups that start on the same register, and a source placed low inside the destination.
- R8: End indices are formed one bit wider than register numbers, so groups that reach past register 31 do not wrap around and hide an overlap.
- R9: `legal` and `illegal` are always complements of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lmul_code | input | 3 | Current group multiplier code |
| dst_reg | input | 5 | First register of the destination group |
| src_reg | input | 5 | First register of the source group |
| src_regs | input | 4 | Number of registers in the source group (1 to 8) |
| dst_regs | output | 4 | Registers in the destination group, 0 when the multiplier is unusable |
| legal | output | 1 | Register groups are acceptable |
| illegal | output | 1 | Illegal-instruction condition |

## Verification
The assertions take for granted that `src_regs` is a real group size between 1 and 8. A size of zero would make the same-start rule vacuous, so the rule is only stated for nonzero sizes. Every directed scenario drives sizes of 1, 2, 4 or 8. Register numbers cover the whole 0 to 31 range, including groups whose end index goes past 31.

// File: rtl/widen_group_chk.sv
module widen_group_chk #(
  parameter int REG_W = 5,
  parameter int CNT_W = 4
) (
  input  logic [2:0]       lmul_code,
  input  logic [REG_W-1:0] dst_reg,
  input  logic [REG_W-1:0] src_reg,
  input  logic [CNT_W-1:0] src_regs,
  output logic [CNT_W-1:0] dst_regs,
  output logic             legal,
  output logic             illegal
);
  localparam int END_W = REG_W + 1;

  logic [CNT_W-1:0] grp;
  logic             mul_ok;

  always_comb begin
    mul_ok = 1'b1;
    grp    = '0;
    unique case (lmul_code)
      3'b000:  grp = CNT_W'(2);
      3'b001:  grp = CNT_W'(4);
      3'b010:  grp = CNT_W'(8);
      3'b101,
      3'b110,
      3'b111:  grp = CNT_W'(1);
      default: mul_ok = 1'b0;
    endcase
  end

  assign dst_regs = grp;

  logic [END_W-1:0] d_lo, d_hi, s_lo, s_hi;
  assign d_lo = END_W'(dst_reg);
  assign s_lo = END_W'(src_reg);
  assign d_hi = d_lo + END_W'(grp);
  assign s_hi = s_lo + END_W'(src_regs);

  logic apart, top_fit;
  assign apart   = (s_lo >= d_hi) || (d_lo >= s_hi);
  assign top_fit = (grp > src_regs) && (s_lo == d_hi - END_W'(src_regs));

  assign illegal = !mul_ok || !(apart || top_fit);
  assign legal   = !illegal;

  always_comb begin
    // R9
    flag_excl_chk: assert (legal ^ illegal);
    // R1
    grp_pow2_chk: assert ($onehot0(dst_regs));
    // R3
    wide_range_chk: assert (lmul_code != 3'b011 || (illegal && dst_regs == '0));
    // R4
    reserved_code_chk: assert (lmul_code != 3'b100 || (illegal && dst_regs == '0));
    // R7
    same_start_chk: assert (!(dst_regs != '0 && src_regs != '0 && dst_reg == src_reg) || illegal);
  end
endmodule

// File: tb/test_widen_group_chk.sv
module test_widen_group_chk;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] lmul_code;
  logic [4:0] dst_reg, src_reg;
  logic [3:0] src_regs, dst_regs;
  logic       legal, illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  widen_group_chk i_widen_group_chk (
    .lmul_code(lmul_code), .dst_reg(dst_reg), .src_reg(src_reg),
    .src_regs(src_regs), .dst_regs(dst_regs), .legal(legal), .illegal(illegal)
  );

  task automatic apply(input logic [2:0] m, input int d, input int s, input int n);
    @(negedge clk);
    lmul_code = m;
    dst_reg   = 5'(d);
    src_reg   = 5'(s);
    src_regs  = 4'(n);
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string req, input int exp_regs, input bit exp_legal);
    checks++;
    if (dst_regs != 4'(exp_regs) || legal != exp_legal || illegal != !exp_legal) begin
      fails++;
      $display("FAIL %s: dst_regs=%0d legal=%0b illegal=%0b, expected dst_regs=%0d legal=%0b illegal=%0b",
               req, dst_regs, legal, illegal, exp_regs, exp_legal, !exp_legal);
    end
  endtask

  task automatic t_reset_state;
    apply(3'b000, 0, 16, 1);
    expect_out("R1 initial", 2, 1'b1);
  endtask

  task automatic t_integral;
    apply(3'b000, 4, 8, 1);  expect_out("R1 m=1", 2, 1'b1);
    apply(3'b001, 8, 0, 2);  expect_out("R1 m=2", 4, 1'b1);
    apply(3'b010, 16, 0, 4); expect_out("R1 m=4", 8, 1'b1);
  endtask

  task automatic t_fractional;
    apply(3'b101, 3, 9, 1);  expect_out("R2 m=1/8", 1, 1'b1);
    apply(3'b110, 3, 4, 1);  expect_out("R2 m=1/4", 1, 1'b1);
    apply(3'b111, 5, 2, 1);  expect_out("R2 m=1/2", 1, 1'b1);
  endtask

  task automatic t_too_wide;
    apply(3'b011, 0, 16, 8); expect_out("R3 m=8 doubled", 0, 1'b0);
  endtask

  task automatic t_reserved;
    apply(3'b100, 0, 16, 1); expect_out("R4 reserved disjoint", 0, 1'b0);
    apply(3'b100, 8, 8, 1);  expect_out("R4 reserved same reg", 0, 1'b0);
  endtask

  task automatic t_disjoint;
    apply(3'b001, 4, 8, 2);  expect_out("R5 src at dst end", 4, 1'b1);
    apply(3'b001, 8, 6, 2);  expect_out("R5 dst at src end", 4, 1'b1);
  endtask

  task automatic t_top_overlap;
    apply(3'b001, 8, 10, 2); expect_out("R6 src in top half", 4, 1'b1);
    apply(3'b000, 6, 7, 1);  expect_out("R6 single src top", 2, 1'b1);
    apply(3'b010, 16, 20, 4); expect_out("R6 m=4 top", 8, 1'b1);
  endtask

  task automatic t_bad_overlap;
    apply(3'b001, 8, 8, 2);  expect_out("R7 same start", 4, 1'b0);
    apply(3'b001, 8, 9, 2);  expect_out("R7 middle", 4, 1'b0);
    apply(3'b000, 6, 6, 2);  expect_out("R7 equal sizes", 2, 1'b0);
    apply(3'b001, 8, 11, 2); expect_out("R7 straddles end", 4, 1'b0);
    apply(3'b000, 6, 5, 2);  expect_out("R7 src below dst", 2, 1'b0);
    apply(3'b111, 3, 3, 1);  expect_out("R7 fractional same reg", 1, 1'b0);
  endtask

  task automatic t_high_regs;
    apply(3'b001, 31, 31, 2); expect_out("R8 no wrap overlap", 4, 1'b0);
    apply(3'b001, 28, 30, 2); expect_out("R8 top fit at 31", 4, 1'b1);
    apply(3'b010, 28, 2, 1);  expect_out("R8 long dst past 31", 8, 1'b1);
  endtask

  task automatic t_complement;
    for (int m = 0; m < 8; m++) begin
      apply(3'(m), 12, 13, 1);
      checks++;
      if (legal == illegal) begin
        fails++;
        $display("FAIL R9: legal=%0b illegal=%0b, expected complements", legal, illegal);
      end
    end
  endtask

  initial begin
    lmul_code = 3'b000; dst_reg = '0; src_reg = 5'd16; src_regs = 4'd1;
    t_reset_state();
    t_integral();
    t_fractional();
    t_too_wide();
    t_reserved();
    t_disjoint();
    t_top_overlap();
    t_bad_overlap();
    t_high_regs();
    t_complement();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule